// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a processor load/store port and a word-wide main-memory port. The memory is byte-addressed and has a 10-bit address, so it spans 1 KB. The cache holds 32 words as 4 sets of 2 ways, and each way holds one 4-word line. For every access, both ways of the addressed set are checked for a valid entry whose stored tag equals the address tag.

On a hit, a read returns the word and a write updates only the cached copy, which marks the line dirty. On a miss, a victim way is chosen. If the victim holds a dirty line, that line is first written back to memory one word at a time. The wanted line is then fetched one word at a time into the victim way. After the fetch, the access is replayed against the filled line. A write miss therefore allocates the line and then merges the write into it.

On the processor side, a request is accepted on a valid/ready handshake and the result comes back as a one-cycle response pulse. On the memory side, the cache issues one word request at a time and holds it until the memory acknowledges it.

Top module: `wb_cache2w`

## Requirements
- R1: Reset clears every valid and dirty bit and every replacement bit. After reset, `cpu_req_ready` is 1 while `cpu_rsp_valid` and `mem_req_valid` are 0, and the first access to any address is a miss.
- R2: The address fields are: bits [9:6] tag, bits [5:4] set, bits [3:2] word within the line. Bits [1:0] select a byte and have no effect on which word is accessed.
- R3: A read hit returns the stored word with no memory request. The response pulse `cpu_rsp_valid` lasts one cycle and comes in the second cycle after the cycle in which the request is accepted.
- R4: A write hit changes only the cached word and sets that way's dirty bit. Main memory keeps its old value until the line is evicted.
- R5: On a miss, the cache reads the aligned line that holds the address, at word offsets 0, 1, 2 and 3 in that order. It then returns the requested word.
- R6: A dirty victim is written back before the fetch begins. The write-back covers its 4 words in ascending offset order, at the addresses formed from the victim's own tag. A clean or invalid victim causes no memory write.
- R7: A write miss fetches the line first and then merges the write into it. The merged line is dirty, so its new value reaches memory when the line is later evicted. A write response carries the written data on `cpu_rsp_rdata`.
- R8: Victim choice follows this order. If way 0 is invalid, way 0 is chosen. Otherwise, if way 1 is invalid, way 1 is chosen. Otherwise the way that was filled less recently in that set is chosen.
- R9: A memory request holds its address, direction and data stable until the cycle in which `mem_ack` is sampled high. Each acknowledge completes exactly one word, so every burst has exactly 4 words.
- R10: `cpu_req_ready` goes low in the cycle after a request is accepted. It stays low through the whole miss sequence and comes back only with the response.
- R11: Every read returns the value most recently written to that word address. If the word has never been written, the read returns the memory's initial contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 10 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read data, or the written data for a write |
| mem_req_valid | output | 1 | Memory word request present |
| mem_req_write | output | 1 | 1 = write-back word, 0 = fill word |
| mem_req_addr | output | 10 | Word-aligned memory byte address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |

## Verification
The bench builds the cache with its default parameters: 32-bit words, a 4-bit tag, 2 set-index bits and 2 word-offset bits. With only four sets, a handful of addresses is enough to fill both ways of a set and force an eviction. The directed cases use this to check the invalid-way-first order, the less-recently-filled victim choice and the dirty write-back ahead of a refill. The random phase draws tags from a pool of six, so evictions happen often. It also varies the memory acknowledge delay, which keeps requests waiting across several cycles.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WBACK,
      ST_FILL
   } cache_state_e;

endpackage

// File: rtl/cache2w_tagstore.sv
module cache2w_tagstore #(
   parameter int TAG_W = 4,
   parameter int IDX_W = 2,
   parameter int WAYS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             set_idx,
   output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   output logic [WAYS-1:0]              way_valid,
   output logic [WAYS-1:0]              way_dirty,
   output logic                         older_way,
   input  logic                         fill_done,
   input  logic                         fill_way,
   input  logic [TAG_W-1:0]             fill_tag,
   input  logic                         mark_dirty,
   input  logic                         dirty_way
);
   localparam int SETS = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic             valid_q [SETS][WAYS];
   logic             dirty_q [SETS][WAYS];
   logic             older_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            older_q[s] <= 1'b0;
         end else if (fill_done && set_idx == IDX_W'(s)) begin
            older_q[s] <= ~fill_way;
         end
      end
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[s][w]   <= '0;
               valid_q[s][w] <= 1'b0;
               dirty_q[s][w] <= 1'b0;
            end else if (set_idx == IDX_W'(s)) begin
               if (fill_done && fill_way == w[0]) begin
                  tag_q[s][w]   <= fill_tag;
                  valid_q[s][w] <= 1'b1;
                  dirty_q[s][w] <= 1'b0;
               end else if (mark_dirty && dirty_way == w[0]) begin
                  dirty_q[s][w] <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         way_tag[w]   = tag_q[set_idx][w];
         way_valid[w] = valid_q[set_idx][w];
         way_dirty[w] = dirty_q[set_idx][w];
      end
      older_way = older_q[set_idx];
   end

endmodule

// File: rtl/cache2w_datastore.sv
module cache2w_datastore #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2,
   parameter int OFF_W  = 2,
   parameter int WAYS   = 2
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  set_idx,
   input  logic              rd_way,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_word,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int ENTRIES = (1 << IDX_W) * WAYS * (1 << OFF_W);
   localparam int ENT_W   = IDX_W + 1 + OFF_W;

   logic [DATA_W-1:0] store_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store_q[ENT_W'({set_idx, wr_way, wr_off})] <= wr_data;
      end
   end

   assign rd_word = store_q[ENT_W'({set_idx, rd_way, rd_off})];

endmodule

// File: rtl/cache2w_match.sv
module cache2w_match #(
   parameter int TAG_W = 4,
   parameter int WAYS  = 2
) (
   input  logic [TAG_W-1:0]           look_tag,
   input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
   input  logic [WAYS-1:0]            way_valid,
   output logic                       hit,
   output logic                       hit_way
);
   logic [WAYS-1:0] hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == look_tag);
   end

   assign hit     = |hit_vec;
   assign hit_way = hit_vec[1];

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
   import cache2w_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 2,
   parameter int OFF_W  = 2,
   parameter int BOFF_W = 2,
   parameter int WAYS   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_req_valid,
   input  logic                         cpu_req_write,
   input  logic [ADDR_W-1:BOFF_W]       cpu_word_addr,
   input  logic [DATA_W-1:0]            cpu_req_wdata,
   output logic                         cpu_req_ready,
   output logic                         cpu_rsp_valid,
   output logic [DATA_W-1:0]            cpu_rsp_rdata,
   output logic                         mem_req_valid,
   output logic                         mem_req_write,
   output logic [ADDR_W-1:0]            mem_req_addr,
   output logic [DATA_W-1:0]            mem_req_wdata,
   input  logic                         mem_ack,
   input  logic [DATA_W-1:0]            mem_rdata,
   output logic [IDX_W-1:0]             set_idx,
   output logic [TAG_W-1:0]             look_tag,
   input  logic                         hit,
   input  logic                         hit_way,
   input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
   input  logic [WAYS-1:0]              way_valid,
   input  logic [WAYS-1:0]              way_dirty,
   input  logic                         older_way,
   output logic                         rd_way,
   output logic [OFF_W-1:0]             rd_off,
   input  logic [DATA_W-1:0]            rd_word,
   output logic                         wr_en,
   output logic                         wr_way,
   output logic [OFF_W-1:0]             wr_off,
   output logic [DATA_W-1:0]            wr_data,
   output logic                         fill_done,
   output logic                         fill_way,
   output logic                         mark_dirty,
   output logic                         dirty_way
);
   localparam int              WA_W     = ADDR_W - BOFF_W;
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((1 << OFF_W) - 1);

   cache_state_e      st_q;
   logic [WA_W-1:0]   req_q;
   logic              wr_q;
   logic [DATA_W-1:0] wd_q;
   logic              vict_q;
   logic [OFF_W-1:0]  cnt_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   logic [OFF_W-1:0]  req_off;
   logic              victim;

   assign look_tag = req_q[WA_W-1 -: TAG_W];
   assign set_idx  = req_q[OFF_W +: IDX_W];
   assign req_off  = req_q[OFF_W-1:0];

   // invalid way 0, then invalid way 1, then the less recently filled way
   always_comb begin
      if (!way_valid[0])      victim = 1'b0;
      else if (!way_valid[1]) victim = 1'b1;
      else                    victim = older_way;
   end

   always_comb begin
      cpu_req_ready = (st_q == ST_IDLE);
      mem_req_valid = 1'b0;
      mem_req_write = 1'b0;
      mem_req_addr  = '0;
      mem_req_wdata = '0;
      rd_way        = vict_q;
      rd_off        = cnt_q;
      wr_en         = 1'b0;
      wr_way        = vict_q;
      wr_off        = cnt_q;
      wr_data       = mem_rdata;
      fill_done     = 1'b0;
      fill_way      = vict_q;
      mark_dirty    = 1'b0;
      dirty_way     = hit_way;
      case (st_q)
         ST_LOOK: begin
            rd_way = hit_way;
            rd_off = req_off;
            if (hit && wr_q) begin
               wr_en      = 1'b1;
               wr_way     = hit_way;
               wr_off     = req_off;
               wr_data    = wd_q;
               mark_dirty = 1'b1;
            end
         end
         ST_WBACK: begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            mem_req_addr  = {way_tag[vict_q], set_idx, cnt_q, {BOFF_W{1'b0}}};
            mem_req_wdata = rd_word;
         end
         ST_FILL: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = {look_tag, set_idx, cnt_q, {BOFF_W{1'b0}}};
            if (mem_ack) begin
               wr_en     = 1'b1;
               fill_done = (cnt_q == LAST_OFF);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         req_q   <= '0;
         wr_q    <= 1'b0;
         wd_q    <= '0;
         vict_q  <= 1'b0;
         cnt_q   <= '0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (cpu_req_valid) begin
                  req_q <= cpu_word_addr;
                  wr_q  <= cpu_req_write;
                  wd_q  <= cpu_req_wdata;
                  st_q  <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (hit) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= wr_q ? wd_q : rd_word;
                  st_q    <= ST_IDLE;
               end else begin
                  vict_q <= victim;
                  cnt_q  <= '0;
                  st_q   <= (way_valid[victim] && way_dirty[victim]) ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_OFF) st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST_OFF) st_q <= ST_LOOK;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_rsp_valid = rsp_v_q;
   assign cpu_rsp_rdata = rsp_d_q;

endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4,
   parameter int IDX_W  = 2,
   parameter int OFF_W  = 2,
   parameter int WAYS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_req_ready,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int BOFF_W = $clog2(DATA_W / 8);

   if (TAG_W + IDX_W + OFF_W + BOFF_W != ADDR_W) begin : g_chk_split
      $error("address fields do not add up to ADDR_W");
   end
   if (WAYS != 2) begin : g_chk_ways
      $error("replacement logic supports exactly two ways");
   end
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_chk_data
      $error("DATA_W must be a whole number of bytes, at least two");
   end

   logic [IDX_W-1:0]           set_idx;
   logic [TAG_W-1:0]           look_tag;
   logic [WAYS-1:0][TAG_W-1:0] way_tag;
   logic [WAYS-1:0]            way_valid;
   logic [WAYS-1:0]            way_dirty;
   logic                       older_way;
   logic                       hit;
   logic                       hit_way;
   logic                       rd_way;
   logic [OFF_W-1:0]           rd_off;
   logic [DATA_W-1:0]          rd_word;
   logic                       wr_en;
   logic                       wr_way;
   logic [OFF_W-1:0]           wr_off;
   logic [DATA_W-1:0]          wr_data;
   logic                       fill_done;
   logic                       fill_way;
   logic                       mark_dirty;
   logic                       dirty_way;

   cache2w_tagstore #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (set_idx),
      .way_tag    (way_tag),
      .way_valid  (way_valid),
      .way_dirty  (way_dirty),
      .older_way  (older_way),
      .fill_done  (fill_done),
      .fill_way   (fill_way),
      .fill_tag   (look_tag),
      .mark_dirty (mark_dirty),
      .dirty_way  (dirty_way)
   );

   cache2w_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
      .look_tag  (look_tag),
      .way_tag   (way_tag),
      .way_valid (way_valid),
      .hit       (hit),
      .hit_way   (hit_way)
   );

   cache2w_datastore #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_data (
      .clk     (clk),
      .set_idx (set_idx),
      .rd_way  (rd_way),
      .rd_off  (rd_off),
      .rd_word (rd_word),
      .wr_en   (wr_en),
      .wr_way  (wr_way),
      .wr_off  (wr_off),
      .wr_data (wr_data)
   );

   cache2w_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .BOFF_W(BOFF_W), .WAYS(WAYS)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (cpu_req_valid),
      .cpu_req_write (cpu_req_write),
      .cpu_word_addr (cpu_req_addr[ADDR_W-1:BOFF_W]),
      .cpu_req_wdata (cpu_req_wdata),
      .cpu_req_ready (cpu_req_ready),
      .cpu_rsp_valid (cpu_rsp_valid),
      .cpu_rsp_rdata (cpu_rsp_rdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_ack       (mem_ack),
      .mem_rdata     (mem_rdata),
      .set_idx       (set_idx),
      .look_tag      (look_tag),
      .hit           (hit),
      .hit_way       (hit_way),
      .way_tag       (way_tag),
      .way_valid     (way_valid),
      .way_dirty     (way_dirty),
      .older_way     (older_way),
      .rd_way        (rd_way),
      .rd_off        (rd_off),
      .rd_word       (rd_word),
      .wr_en         (wr_en),
      .wr_way        (wr_way),
      .wr_off        (wr_off),
      .wr_data       (wr_data),
      .fill_done     (fill_done),
      .fill_way      (fill_way),
      .mark_dirty    (mark_dirty),
      .dirty_way     (dirty_way)
   );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
   parameter int ADDR_W = 10,
   parameter int OFF_LO = 2,
   parameter int OFF_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_req_ready,
   input logic              cpu_rsp_valid,
   input logic              mem_req_valid,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_ack
);
   logic [OFF_W-1:0] off;
   assign off = mem_req_addr[OFF_LO +: OFF_W];

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

   a_r10_no_accept_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !cpu_req_ready);

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |=> !cpu_rsp_valid);

   a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_ack |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

   a_r5_ascending_words: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_ack && (off != {OFF_W{1'b1}}) |=>
         mem_req_valid && (mem_req_write == $past(mem_req_write)) &&
         (off == $past(off) + 1'b1));

   a_r6_wb_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> off == '0);

endmodule

bind wb_cache2w cache2w_chk #(.ADDR_W(ADDR_W), .OFF_LO(BOFF_W), .OFF_W(OFF_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_ready (cpu_req_ready),
   .cpu_rsp_valid (cpu_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_ack       (mem_ack)
);

// File: tb/sim_wb_cache2w.sv
`timescale 1ns/1ps
module sim_wb_cache2w;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0;
   logic        cpu_req_write = 1'b0;
   logic [9:0]  cpu_req_addr = '0;
   logic [31:0] cpu_req_wdata = '0;
   logic        cpu_req_ready;
   logic        cpu_rsp_valid;
   logic [31:0] cpu_rsp_rdata;
   logic        mem_req_valid;
   logic        mem_req_write;
   logic [9:0]  mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #5 clk = ~clk;

   wb_cache2w u0 (.*);

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [31:0] backing [256];
   logic [31:0] shadow  [256];
   int lat_max = 0;
   int dly = 0;
   int rd_cnt, wr_cnt;
   bit wr_after_rd;
   logic [9:0] rd_log [8];
   logic [9:0] wr_log [8];

   function automatic logic [9:0] mk(input int tag, input int set, input int off);
      return 10'((tag << 6) | (set << 4) | (off << 2));
   endfunction

   function automatic logic [31:0] init_word(input int i);
      return 32'hA5000000 ^ (32'(i) * 32'h00010203) ^ 32'(i << 3);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req_valid && rst_n) begin
            if (dly > 0) begin
               dly--;
            end else begin
               if (mem_req_write) begin
                  if (wr_cnt < 8) wr_log[wr_cnt] = mem_req_addr;
                  wr_cnt++;
                  if (rd_cnt > 0) wr_after_rd = 1'b1;
                  backing[mem_req_addr[9:2]] = mem_req_wdata;
               end else begin
                  if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
                  rd_cnt++;
                  mem_rdata = backing[mem_req_addr[9:2]];
               end
               mem_ack = 1'b1;
               dly = (lat_max > 0) ? int'($urandom % (lat_max + 1)) : 0;
            end
         end
      end
   end

   task automatic do_op(input bit wr, input logic [9:0] addr, input logic [31:0] wd,
                        output logic [31:0] rdata, output int lat);
      int guard;
      rd_cnt = 0; wr_cnt = 0; wr_after_rd = 0;
      @(negedge clk);
      chk(cpu_req_ready, "R10 ready before request", 32'(cpu_req_ready), 32'd1);
      cpu_req_valid = 1'b1;
      cpu_req_write = wr;
      cpu_req_addr  = addr;
      cpu_req_wdata = wd;
      @(posedge clk);
      #1 cpu_req_valid = 1'b0;
      lat = 0;
      guard = 0;
      rdata = '0;
      forever begin
         @(negedge clk);
         lat++;
         if (cpu_rsp_valid) begin
            rdata = cpu_rsp_rdata;
            break;
         end
         if (cpu_req_ready) begin
            chk(1'b0, "R10 ready low until response", 32'd1, 32'd0);
            break;
         end
         guard++;
         if (guard > 200) begin
            chk(1'b0, "R10 response missing", 32'd0, 32'd1);
            break;
         end
      end
      if (wr) shadow[addr[9:2]] = wd;
   endtask

   task automatic check_burst(input bit is_wr, input logic [9:0] line_addr, input string req);
      for (int k = 0; k < 4; k++) begin
         logic [9:0] got;
         got = is_wr ? wr_log[k] : rd_log[k];
         chk(got == (line_addr | 10'(k << 2)), req, 32'(got), 32'(line_addr | 10'(k << 2)));
      end
   endtask

   initial begin
      logic [31:0] rd;
      int lat;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin
         backing[i] = init_word(i);
         shadow[i]  = init_word(i);
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_req_ready == 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 32'd1);
      chk(cpu_rsp_valid == 1'b0, "R1 no response after reset", 32'(cpu_rsp_valid), 32'd0);
      chk(mem_req_valid == 1'b0, "R1 no memory request after reset", 32'(mem_req_valid), 32'd0);

      // R1 R5: first access misses, fills aligned line in order
      do_op(0, mk(1, 0, 2), 0, rd, lat);
      chk(rd == shadow[mk(1, 0, 2) >> 2], "R5 miss returns requested word", rd, shadow[mk(1, 0, 2) >> 2]);
      chk(rd_cnt == 4, "R1 first access misses with 4 reads", 32'(rd_cnt), 32'd4);
      chk(wr_cnt == 0, "R6 invalid victim no write", 32'(wr_cnt), 32'd0);
      check_burst(0, mk(1, 0, 0), "R5 fill order");

      // R3 R2: hit with byte offset set
      do_op(0, mk(1, 0, 1) | 10'd3, 0, rd, lat);
      chk(rd == shadow[mk(1, 0, 1) >> 2], "R2 byte bits ignored on hit", rd, shadow[mk(1, 0, 1) >> 2]);
      chk(rd_cnt + wr_cnt == 0, "R3 hit no memory traffic", 32'(rd_cnt + wr_cnt), 32'd0);
      chk(lat == 2, "R3 hit latency", 32'(lat), 32'd2);

      // R4: write hit stays in cache
      do_op(1, mk(1, 0, 3), 32'hDEAD0001, rd, lat);
      chk(rd_cnt + wr_cnt == 0, "R4 write hit no memory traffic", 32'(rd_cnt + wr_cnt), 32'd0);
      chk(backing[mk(1, 0, 3) >> 2] == init_word(mk(1, 0, 3) >> 2), "R4 memory unchanged",
          backing[mk(1, 0, 3) >> 2], init_word(mk(1, 0, 3) >> 2));
      do_op(0, mk(1, 0, 3), 0, rd, lat);
      chk(rd == 32'hDEAD0001, "R4 cached value readable", rd, 32'hDEAD0001);

      // R8: way 1 invalid is filled next
      do_op(0, mk(2, 0, 0), 0, rd, lat);
      chk(rd_cnt == 4 && wr_cnt == 0, "R8 invalid way 1 filled", 32'(wr_cnt), 32'd0);
      do_op(0, mk(1, 0, 0), 0, rd, lat);
      chk(rd_cnt == 0, "R8 way 0 retained", 32'(rd_cnt), 32'd0);

      // R6: oldest way 0 (dirty) is written back before refill
      do_op(0, mk(3, 0, 1), 0, rd, lat);
      chk(wr_cnt == 4, "R6 dirty victim written back", 32'(wr_cnt), 32'd4);
      chk(rd_cnt == 4, "R6 refill after write-back", 32'(rd_cnt), 32'd4);
      chk(!wr_after_rd, "R6 write-back precedes fill", 32'(wr_after_rd), 32'd0);
      check_burst(1, mk(1, 0, 0), "R6 write-back order and tag");
      chk(backing[mk(1, 0, 3) >> 2] == 32'hDEAD0001, "R6 dirty data reached memory",
          backing[mk(1, 0, 3) >> 2], 32'hDEAD0001);
      chk(rd == shadow[mk(3, 0, 1) >> 2], "R5 refill returns word", rd, shadow[mk(3, 0, 1) >> 2]);

      // R8: way 1 (tag 2) was kept, then becomes the next victim
      do_op(0, mk(2, 0, 1), 0, rd, lat);
      chk(rd_cnt == 0, "R8 newer way kept on eviction", 32'(rd_cnt), 32'd0);
      do_op(0, mk(1, 0, 0), 0, rd, lat);
      chk(rd_cnt == 4 && wr_cnt == 0, "R8 oldest clean way evicted", 32'(wr_cnt), 32'd0);
      do_op(0, mk(3, 0, 2), 0, rd, lat);
      chk(rd_cnt == 0, "R8 tag 3 survived in way 0", 32'(rd_cnt), 32'd0);

      // R7: write miss allocates, merges, later writes back
      do_op(1, mk(5, 1, 2), 32'hBEEF0007, rd, lat);
      chk(rd_cnt == 4 && wr_cnt == 0, "R7 write miss fetches line", 32'(rd_cnt), 32'd4);
      chk(rd == 32'hBEEF0007, "R7 write response data", rd, 32'hBEEF0007);
      chk(backing[mk(5, 1, 2) >> 2] == init_word(mk(5, 1, 2) >> 2), "R7 memory not yet written",
          backing[mk(5, 1, 2) >> 2], init_word(mk(5, 1, 2) >> 2));
      do_op(0, mk(5, 1, 0), 0, rd, lat);
      chk(rd_cnt == 0 && rd == shadow[mk(5, 1, 0) >> 2], "R7 allocated line hits", rd, shadow[mk(5, 1, 0) >> 2]);
      do_op(0, mk(6, 1, 0), 0, rd, lat);
      do_op(0, mk(7, 1, 0), 0, rd, lat);
      chk(wr_cnt == 4, "R7 merged line is dirty", 32'(wr_cnt), 32'd4);
      chk(backing[mk(5, 1, 2) >> 2] == 32'hBEEF0007, "R7 merged word written back",
          backing[mk(5, 1, 2) >> 2], 32'hBEEF0007);

      // R11 R9: random traffic with slow memory
      lat_max = 3;
      for (int n = 0; n < 400; n++) begin
         bit w;
         logic [9:0] a;
         logic [31:0] d;
         w = ($urandom % 10) < 4;
         a = mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 4)) | 10'($urandom % 4);
         d = $urandom;
         do_op(w, a, d, rd, lat);
         if (w) chk(rd == d, "R7 write response", rd, d);
         else   chk(rd == shadow[a[9:2]], "R11 read returns latest value", rd, shadow[a[9:2]]);
         chk((rd_cnt == 0 || rd_cnt == 4) && (wr_cnt == 0 || wr_cnt == 4), "R9 whole-line bursts",
             32'(rd_cnt * 16 + wr_cnt), 32'd0);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule